// File: doc/BRIEF.md
# Virtual Address Segment Classifier

This block sorts every 64-bit virtual address presented by a processor core into one of three outcomes in the same cycle. The address is an address error, or it bypasses translation and lands on a physical address through a fixed window, or it must be looked up in the translation buffer. The decision uses the access kind (fetch, load or store), the privilege level, the 32-bit or 64-bit addressing mode, an error-level override bit and three enables for the extended user, supervisor and kernel spaces.

The two top address bits pick one of four regions: user space, supervisor space, a kernel window onto physical memory, and kernel space. Kernel space contains a compatibility area at its top where two fixed windows map to the low 512 MB of physical memory, one cached and one uncached. In the physical window, three address bits select the cache policy. When a direct window is taken the block also drives the physical address and an uncached flag. An address error is tagged as instruction-side or data-side, so the core can raise the matching exception.

The block is purely combinational, with no clock and no state. It sits between address generation and the translation buffer. Parameters set the implemented virtual address width (`VA_BITS`, default 40) and the physical address width (`PA_W`, default 36).

Top module: `va_seg_classifier`

## Requirements
- R1: Exactly one outcome holds for every input: `addr_error`, `need_tlb`, or a direct mapping (both low). When the outcome is not direct, `direct_pa` is zero and `uncached` is low. Privilege codes: 0 kernel, 1 supervisor, 2 and 3 user.
- R2: Region 0 (bits 63:62 = 00) faults in 32-bit mode when any of bits 63:32 is set. In 64-bit mode it faults when any of bits 61:VA_BITS is set, and also faults on any set bit in 63:32 when the user-extension enable is low.
- R3: A region-0 address that passes R2 while the error-level bit is set is direct and uncached, with `direct_pa` = address bits PA_W-1:0. It faults if any of bits 61:PA_W is set. Without the error-level bit it needs the TLB.
- R4: In the compatibility area (bits 63:31 all ones), user mode always faults. Supervisor mode reaches only the window with bits 30:29 = 10, which goes to the TLB, and faults on the other three windows.
- R5: In kernel mode, compatibility window 00 is direct and cached and window 01 is direct and uncached, both with `direct_pa` = bits 28:0 zero-extended. Windows 10 and 11 need the TLB.
- R6: A region-3 address below the compatibility area needs the TLB only in kernel mode with 64-bit addressing, the kernel-extension enable high and bits 61:VA_BITS all zero. In any other case it faults.
- R7: Region 2 (bits 63:62 = 10) faults unless the access is in kernel mode with 64-bit addressing. Bits 61:59 select the policy: 3, 4 or 5 give direct cached, 2 or 7 give direct uncached, and 0, 1 or 6 fault. The access also faults if any of bits 58:PA_W is set. Otherwise `direct_pa` = bits PA_W-1:0.
- R8: Region 1 (bits 63:62 = 01) needs the TLB only with 64-bit addressing, a non-user mode, the supervisor-extension enable high and bits 61:VA_BITS all zero. In any other case it faults.
- R9: `error_is_ifetch` is high exactly when `addr_error` is high and the access type is 0 (fetch). Types 1 (load), 2 (store) and 3 give a data-side fault with `error_is_ifetch` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr | input | 64 | Virtual address to classify |
| acc_type | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as load |
| priv_mode | input | 2 | 0 kernel, 1 supervisor, 2/3 user |
| wide_mode | input | 1 | 1 selects 64-bit addressing |
| err_lvl | input | 1 | Error-level override of user space |
| ux_en | input | 1 | Extended user addressing enable |
| sx_en | input | 1 | Supervisor region enable |
| kx_en | input | 1 | Extended kernel space enable |
| need_tlb | output | 1 | Address must be translated |
| direct_pa | output | PA_W | Physical address of a direct mapping, else 0 |
| uncached | output | 1 | Direct mapping is uncached |
| addr_error | output | 1 | Address error |
| error_is_ifetch | output | 1 | The fault is instruction-side |

## Verification
The error-level bypass and the range checks can act on the same region-0 access. The bench provokes this with the override bit set on addresses that also carry upper bits in 32-bit mode, carry bits beyond the virtual width, or exceed the physical width. In every such case the fault must win and no physical address may appear. A second collision is the privilege check against the window choice in the compatibility area and the physical window. Here random privilege codes are mixed with addresses aimed at each window, and a reference function decides which rule wins.

// File: rtl/vasc_pkg.sv
package vasc_pkg;

  typedef enum logic [1:0] {
    PRIV_KERN = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_USR  = 2'd2,
    PRIV_USR2 = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    ROUTE_TLB    = 2'd0,
    ROUTE_DIRECT = 2'd1,
    ROUTE_FAULT  = 2'd2
  } route_e;

  typedef struct packed {
    route_e route;
    logic   uncached;
    logic   from_window;
  } verdict_t;

  localparam logic [1:0] RGN_USER  = 2'b00;
  localparam logic [1:0] RGN_SUPV  = 2'b01;
  localparam logic [1:0] RGN_KPHYS = 2'b10;
  localparam logic [1:0] RGN_KERN  = 2'b11;

  localparam logic [1:0] WIN_CACHED = 2'b00;
  localparam logic [1:0] WIN_UNCACH = 2'b01;
  localparam logic [1:0] WIN_SUPV   = 2'b10;

  localparam int WINDOW_BITS = 29;

endpackage

// File: rtl/vasc_bounds.sv
module vasc_bounds #(
  parameter int VA_BITS = 40,
  parameter int PA_W    = 36
) (
  input  logic [63:0] vaddr,
  output logic        hi32_set,
  output logic        xbits_bad,
  output logic        pa_over,
  output logic        kphys_over,
  output logic        compat
);

  assign hi32_set = |vaddr[63:32];
  assign compat   = &vaddr[63:31];

  generate
    if (VA_BITS < 62) begin : g_vlimit
      assign xbits_bad = |vaddr[61:VA_BITS];
    end else begin : g_vfull
      assign xbits_bad = 1'b0;
    end

    if (PA_W < 62) begin : g_plimit
      assign pa_over = |vaddr[61:PA_W];
    end else begin : g_pfull
      assign pa_over = 1'b0;
    end

    if (PA_W < 59) begin : g_klimit
      assign kphys_over = |vaddr[58:PA_W];
    end else begin : g_kfull
      assign kphys_over = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/vasc_kphys.sv
module vasc_kphys (
  input  logic [2:0] policy,
  output logic       pol_ok,
  output logic       pol_uncached
);

  always_comb begin
    pol_ok       = 1'b0;
    pol_uncached = 1'b0;
    unique case (policy)
      3'd3, 3'd4, 3'd5: pol_ok = 1'b1;
      3'd2, 3'd7: begin
        pol_ok       = 1'b1;
        pol_uncached = 1'b1;
      end
      default: pol_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/vasc_rules.sv
module vasc_rules
  import vasc_pkg::*;
(
  input  logic [1:0] region,
  input  logic [1:0] window,
  input  logic [1:0] priv_mode,
  input  logic       wide_mode,
  input  logic       err_lvl,
  input  logic       ux_en,
  input  logic       sx_en,
  input  logic       kx_en,
  input  logic       hi32_set,
  input  logic       xbits_bad,
  input  logic       pa_over,
  input  logic       kphys_over,
  input  logic       compat,
  input  logic       pol_ok,
  input  logic       pol_uncached,
  output verdict_t   verdict
);

  logic is_kern;
  logic is_sup;
  logic is_usr;
  logic fault;
  logic direct;
  logic unc;
  logic win;

  assign is_kern = (priv_mode == PRIV_KERN);
  assign is_sup  = (priv_mode == PRIV_SUP);
  assign is_usr  = priv_mode[1];

  always_comb begin
    fault  = 1'b0;
    direct = 1'b0;
    unc    = 1'b0;
    win    = 1'b0;
    unique case (region)
      RGN_USER: begin
        if (!wide_mode && hi32_set) begin
          fault = 1'b1;
        end else if (wide_mode && (xbits_bad || (!ux_en && hi32_set))) begin
          fault = 1'b1;
        end else if (err_lvl) begin
          if (pa_over) begin
            fault = 1'b1;
          end else begin
            direct = 1'b1;
            unc    = 1'b1;
          end
        end
      end
      RGN_SUPV: begin
        fault = !wide_mode || is_usr || !sx_en || xbits_bad;
      end
      RGN_KPHYS: begin
        if (!wide_mode || !is_kern || !pol_ok || kphys_over) begin
          fault = 1'b1;
        end else begin
          direct = 1'b1;
          unc    = pol_uncached;
        end
      end
      default: begin
        if (compat) begin
          if (is_usr) begin
            fault = 1'b1;
          end else if (is_sup) begin
            fault = (window != WIN_SUPV);
          end else if (window == WIN_CACHED || window == WIN_UNCACH) begin
            direct = 1'b1;
            win    = 1'b1;
            unc    = (window == WIN_UNCACH);
          end
        end else begin
          fault = !wide_mode || !is_kern || !kx_en || xbits_bad;
        end
      end
    endcase
  end

  always_comb begin
    verdict.uncached    = 1'b0;
    verdict.from_window = 1'b0;
    if (fault) begin
      verdict.route = ROUTE_FAULT;
    end else if (direct) begin
      verdict.route       = ROUTE_DIRECT;
      verdict.uncached    = unc;
      verdict.from_window = win;
    end else begin
      verdict.route = ROUTE_TLB;
    end
  end

endmodule

// File: rtl/va_seg_classifier.sv
module va_seg_classifier
  import vasc_pkg::*;
#(
  parameter int VA_BITS = 40,
  parameter int PA_W    = 36
) (
  input  logic [63:0]     vaddr,
  input  logic [1:0]      acc_type,
  input  logic [1:0]      priv_mode,
  input  logic            wide_mode,
  input  logic            err_lvl,
  input  logic            ux_en,
  input  logic            sx_en,
  input  logic            kx_en,
  output logic            need_tlb,
  output logic [PA_W-1:0] direct_pa,
  output logic            uncached,
  output logic            addr_error,
  output logic            error_is_ifetch
);

  localparam logic [1:0] ACC_FETCH = 2'd0;

  logic     hi32_set;
  logic     xbits_bad;
  logic     pa_over;
  logic     kphys_over;
  logic     compat;
  logic     pol_ok;
  logic     pol_uncached;
  verdict_t verdict;

  vasc_bounds #(
    .VA_BITS(VA_BITS),
    .PA_W   (PA_W)
  ) u_bounds (
    .vaddr     (vaddr),
    .hi32_set  (hi32_set),
    .xbits_bad (xbits_bad),
    .pa_over   (pa_over),
    .kphys_over(kphys_over),
    .compat    (compat)
  );

  vasc_kphys u_kphys (
    .policy      (vaddr[61:59]),
    .pol_ok      (pol_ok),
    .pol_uncached(pol_uncached)
  );

  vasc_rules u_rules (
    .region      (vaddr[63:62]),
    .window      (vaddr[30:29]),
    .priv_mode   (priv_mode),
    .wide_mode   (wide_mode),
    .err_lvl     (err_lvl),
    .ux_en       (ux_en),
    .sx_en       (sx_en),
    .kx_en       (kx_en),
    .hi32_set    (hi32_set),
    .xbits_bad   (xbits_bad),
    .pa_over     (pa_over),
    .kphys_over  (kphys_over),
    .compat      (compat),
    .pol_ok      (pol_ok),
    .pol_uncached(pol_uncached),
    .verdict     (verdict)
  );

  always_comb begin
    direct_pa = '0;
    if (verdict.route == ROUTE_DIRECT) begin
      if (verdict.from_window) begin
        direct_pa = PA_W'(vaddr[WINDOW_BITS-1:0]);
      end else begin
        direct_pa = vaddr[PA_W-1:0];
      end
    end
  end

  assign need_tlb        = (verdict.route == ROUTE_TLB);
  assign addr_error      = (verdict.route == ROUTE_FAULT);
  assign uncached        = verdict.uncached;
  assign error_is_ifetch = addr_error && (acc_type == ACC_FETCH);

endmodule

// File: rtl/va_seg_classifier_chk.sv
module va_seg_classifier_chk #(
  parameter int PA_W = 36
) (
  input logic [1:0]      region,
  input logic [1:0]      acc_type,
  input logic [1:0]      priv_mode,
  input logic            wide_mode,
  input logic            err_lvl,
  input logic            need_tlb,
  input logic [PA_W-1:0] direct_pa,
  input logic            uncached,
  input logic            addr_error,
  input logic            error_is_ifetch
);

  always_comb begin
    AST_ONE_ROUTE: assert (!(need_tlb && addr_error)); // R1
    if (need_tlb || addr_error) begin
      AST_QUIET_PA: assert (direct_pa == '0 && !uncached); // R1
    end
    if (region == 2'b00 && err_lvl) begin
      AST_ERL_BYPASS: assert (!need_tlb); // R3
    end
    if (priv_mode[1] && region != 2'b00) begin
      AST_USER_LOCKOUT: assert (addr_error); // R4
    end
    if (region == 2'b10 && (!wide_mode || priv_mode != 2'b00)) begin
      AST_KPHYS_GATE: assert (addr_error); // R7
    end
    if (region == 2'b01 && !wide_mode) begin
      AST_SUPV_NARROW: assert (addr_error); // R8
    end
    if (error_is_ifetch) begin
      AST_IFETCH_SIDE: assert (addr_error && acc_type == 2'b00); // R9
    end
  end

endmodule

bind va_seg_classifier va_seg_classifier_chk #(
  .PA_W(PA_W)
) u_chk (
  .region         (vaddr[63:62]),
  .acc_type       (acc_type),
  .priv_mode      (priv_mode),
  .wide_mode      (wide_mode),
  .err_lvl        (err_lvl),
  .need_tlb       (need_tlb),
  .direct_pa      (direct_pa),
  .uncached       (uncached),
  .addr_error     (addr_error),
  .error_is_ifetch(error_is_ifetch)
);

// File: tb/va_seg_classifier_tb.sv
module va_seg_classifier_tb;

  localparam int VA_BITS = 40;
  localparam int PA_W    = 36;

  logic            clk;
  logic [63:0]     vaddr;
  logic [1:0]      acc_type;
  logic [1:0]      priv_mode;
  logic            wide_mode;
  logic            err_lvl;
  logic            ux_en;
  logic            sx_en;
  logic            kx_en;
  logic            need_tlb;
  logic [PA_W-1:0] direct_pa;
  logic            uncached;
  logic            addr_error;
  logic            error_is_ifetch;

  int n_checks = 0;
  int n_errors = 0;

  va_seg_classifier #(.VA_BITS(VA_BITS), .PA_W(PA_W)) u_dut (
    .vaddr(vaddr), .acc_type(acc_type), .priv_mode(priv_mode),
    .wide_mode(wide_mode), .err_lvl(err_lvl), .ux_en(ux_en),
    .sx_en(sx_en), .kx_en(kx_en), .need_tlb(need_tlb),
    .direct_pa(direct_pa), .uncached(uncached), .addr_error(addr_error),
    .error_is_ifetch(error_is_ifetch)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // expected {err, tlb, unc, pa}
  function automatic logic [PA_W+2:0] model(input logic [63:0] va,
      input logic [1:0] pr, input logic wd, input logic erl,
      input logic ux, input logic sx, input logic kx);
    logic err, tlb, unc;
    logic [PA_W-1:0] pa;
    logic kern, sup, usr, xbad;
    err = 1'b0; tlb = 1'b0; unc = 1'b0; pa = '0;
    kern = (pr == 2'd0); sup = (pr == 2'd1); usr = (pr >= 2'd2);
    xbad = ((va[61:0] >> VA_BITS) != 62'd0);
    case (va[63:62])
      2'd0: begin
        if (!wd && va[63:32] != 32'd0) err = 1'b1;
        else if (wd && xbad) err = 1'b1;
        else if (wd && !ux && va[63:32] != 32'd0) err = 1'b1;
        else if (erl) begin
          if ((va[61:0] >> PA_W) != 62'd0) err = 1'b1;
          else begin unc = 1'b1; pa = va[PA_W-1:0]; end
        end else tlb = 1'b1;
      end
      2'd1: begin
        if (!wd || usr || !sx || xbad) err = 1'b1; else tlb = 1'b1;
      end
      2'd2: begin
        if (!wd || !kern) err = 1'b1;
        else if ((va[58:0] >> PA_W) != 59'd0) err = 1'b1;
        else if (va[61:59] == 3'd3 || va[61:59] == 3'd4 || va[61:59] == 3'd5)
          pa = va[PA_W-1:0];
        else if (va[61:59] == 3'd2 || va[61:59] == 3'd7) begin
          pa = va[PA_W-1:0]; unc = 1'b1;
        end else err = 1'b1;
      end
      default: begin
        if (va >= 64'hFFFF_FFFF_8000_0000) begin
          if (usr) err = 1'b1;
          else if (sup) begin
            if (va[30:29] == 2'd2) tlb = 1'b1; else err = 1'b1;
          end else if (va[30:29] == 2'd0) pa = PA_W'(va[28:0]);
          else if (va[30:29] == 2'd1) begin pa = PA_W'(va[28:0]); unc = 1'b1; end
          else tlb = 1'b1;
        end else begin
          if (!wd || !kern || !kx || xbad) err = 1'b1; else tlb = 1'b1;
        end
      end
    endcase
    return {err, tlb, unc, pa};
  endfunction

  task automatic apply(input logic [63:0] va, input logic [1:0] at,
      input logic [1:0] pr, input logic wd, input logic erl,
      input logic ux, input logic sx, input logic kx, input string tag);
    logic [PA_W+2:0] exp_v;
    logic [PA_W+2:0] got_v;
    logic exp_if;
    @(negedge clk);
    vaddr = va; acc_type = at; priv_mode = pr; wide_mode = wd;
    err_lvl = erl; ux_en = ux; sx_en = sx; kx_en = kx;
    @(posedge clk); #1;
    exp_v  = model(va, pr, wd, erl, ux, sx, kx);
    got_v  = {addr_error, need_tlb, uncached, direct_pa};
    exp_if = exp_v[PA_W+2] && (at == 2'd0);
    n_checks++;
    if (got_v !== exp_v) begin
      n_errors++;
      $display("FAIL %s va=%h got err/tlb/unc/pa=%b/%b/%b/%h exp=%b/%b/%b/%h",
               tag, va, got_v[PA_W+2], got_v[PA_W+1], got_v[PA_W], got_v[PA_W-1:0],
               exp_v[PA_W+2], exp_v[PA_W+1], exp_v[PA_W], exp_v[PA_W-1:0]);
    end
    n_checks++;
    if (error_is_ifetch !== exp_if) begin
      n_errors++;
      $display("FAIL R9 va=%h ifetch got=%b exp=%b", va, error_is_ifetch, exp_if);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [63:0] va;
    vaddr = '0; acc_type = '0; priv_mode = '0; wide_mode = 1'b0;
    err_lvl = 1'b0; ux_en = 1'b0; sx_en = 1'b0; kx_en = 1'b0;
    void'($urandom(32'd24681));
    // R1 idle state: zero address in kernel 32-bit mode needs the TLB
    apply(64'h0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 idle");
    // R2 range faults
    apply(64'h0000_0001_0000_0000, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 hi32 narrow");
    apply(64'h0000_0100_0000_0000, 2'd2, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R2 past vbits");
    apply(64'h0000_0001_0000_0000, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 ux off");
    apply(64'h0000_0001_0000_0000, 2'd1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R2 ux on");
    // R3 error-level override and its collisions with range faults
    apply(64'h0000_0000_1234_5678, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 override");
    apply(64'h0000_0010_0000_0000, 2'd2, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R3 pa over");
    apply(64'h0000_0002_0000_0040, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 narrow collide");
    apply(64'h0000_000F_FFFF_FFF8, 2'd1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R3 top of pa");
    // R4 compatibility area privilege
    apply(64'hFFFF_FFFF_8000_1000, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 user fetch");
    apply(64'hFFFF_FFFF_C000_0000, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 sup window");
    apply(64'hFFFF_FFFF_A000_0000, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 sup other");
    // R5 kernel windows
    apply(64'hFFFF_FFFF_8ABC_DEF0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 cached win");
    apply(64'hFFFF_FFFF_A000_0010, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 uncached win");
    apply(64'hFFFF_FFFF_E000_0000, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 mapped win");
    // R6 extended kernel space
    apply(64'hC000_0000_1000_0000, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R6 ok");
    apply(64'hC000_0000_1000_0000, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 kx off");
    apply(64'hC000_0000_1000_0000, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6 narrow");
    // R7 physical window
    apply(64'h9800_0000_1234_5000, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 cached");
    apply(64'h9000_0000_0000_0800, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 uncached");
    apply(64'h8000_0000_0000_0800, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 bad policy");
    apply(64'h9800_0100_0000_0000, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 offset over");
    apply(64'h9800_0000_0000_0000, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 non-kernel");
    // R8 supervisor region
    apply(64'h4000_0000_0000_1000, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8 ok");
    apply(64'h4000_0000_0000_1000, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 sx off");
    apply(64'h4000_0000_0000_1000, 2'd2, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8 user");
    // R9 fault side
    apply(64'h0000_0001_0000_0000, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 fetch");
    apply(64'h0000_0001_0000_0000, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 type3");
    // random mix aimed at each region and window
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] shape;
      va = {$urandom(), $urandom()};
      shape = 4'($urandom_range(0, 9));
      case (shape)
        4'd0, 4'd1: va[63:VA_BITS-1] = '0;
        4'd2: va[63:32] = '0;
        4'd3, 4'd4: va[63:31] = '1;
        4'd5: begin va[63:62] = 2'b10; if ($urandom_range(0, 1) == 0) va[58:PA_W] = '0; end
        4'd6: begin va[63:62] = 2'b01; va[61:VA_BITS-1] = '0; end
        4'd7: begin va[63:62] = 2'b11; va[61:VA_BITS-1] = '0; end
        default: ;
      endcase
      apply(va, 2'($urandom()), 2'($urandom()), 1'($urandom()), 1'($urandom()),
            1'($urandom()), 1'($urandom()), 1'($urandom()),
            va[63:62] == 2'b00 ? "R2/R3 rnd" : va[63:62] == 2'b01 ? "R8 rnd" :
            va[63:62] == 2'b10 ? "R7 rnd" : "R4/R5/R6 rnd");
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule